// File: doc/BRIEF.md
# Two-Slot PCM/ADPCM Sample Interface

This block sits between a TDM byte stream and per-channel voice processing. Each voice sample takes a pair of consecutive time slots. The first slot of the pair holds the sample byte. The second slot is a companion control slot: its two low bits say whether the sample is PCM, ADPCM or padding, or that the ADPCM decompressor must be reset. Because the encoding travels with every sample, a channel can change between PCM and ADPCM from one sample to the next.

A frame pulse that arrives with a slot strobe marks slot 0. Slot pairs are numbered from there, and pair k belongs to channel k.

- **Receive direction.** The block collects both slots of a pair. It then presents the sample, its encoding type and a reset flag, tagged with the channel number.
- **Transmit direction.** The block takes a sample and its attributes from the host at the first slot of a pair. It drives the sample byte, and then the control byte.

In both directions a one-bit history per channel remembers whether that channel's last completed pair was padding. This history lets the block raise the reset indication on a padding-to-voice transition. The host can also force the reset code for the first sample of a talk spurt that follows a suppressed silent period.

Top module: `tsp_iface`

## Requirements
- R1: A frame pulse (`frm_sync`) sampled together with a slot strobe (`slot_en`) makes that slot number 0, and later strobes count upward. Slots 2k and 2k+1 form pair k, which is channel k, for k < NUM_CH. Strobes before the first frame pulse, and strobes at slot 2*NUM_CH and beyond, produce no receive output and change no history.
- R2: In the cycle after the strobe of a pair's second slot, `rx_vld` is high for exactly one cycle. In that cycle `rx_smp` holds the byte of the pair's first slot, and `rx_chan` holds the pair number.
- R3: The receive side decodes bits 1:0 of the control slot as follows. Code 00 gives `rx_kind` 0 (PCM). Code 01 gives `rx_kind` 1 (ADPCM). Code 10 gives `rx_kind` 2 (padding). Code 11 gives `rx_kind` 1 (ADPCM) with `rx_rst` high. Bits 7:2 of the control slot have no effect.
- R4: `rx_rst` is also high for a non-padding sample when the previous completed pair of the same channel was padding. `rx_rst` is never high for a padding sample.
- R5: In the cycle after a first-slot strobe, `tx_byte` equals `tx_smp` as sampled at that strobe. In the cycle after a second-slot strobe, `tx_byte` equals {6'b000000, code}. Between strobes, `tx_byte` holds its value.
- R6: The transmit code is chosen from the inputs sampled at the first-slot strobe, in this order. If `tx_pad` is high, the code is 10. Otherwise, if the channel's previous completed pair was padding or `tx_talk` is high, the code is 11. Otherwise the code is 01 when `tx_adpcm` is high and 00 when it is low.
- R7: A pair whose second slot never arrives because a frame pulse intervenes is dropped. It produces no `rx_vld`, and it updates neither the receive history nor the transmit history.
- R8: After reset, `rx_vld`, `rx_rst` and `tx_byte` are zero. Both histories read as "previous pair was not padding", and the slot counter is idle until a frame pulse arrives.
- R9: A strobe at a slot outside the pair range sets `tx_byte` to zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_en | input | 1 | One-cycle strobe per TDM slot |
| frm_sync | input | 1 | Frame pulse; marks the strobed slot as slot 0 |
| rx_byte | input | 8 | Received slot byte |
| rx_vld | output | 1 | Receive pair complete |
| rx_smp | output | 8 | Received sample byte |
| rx_kind | output | 2 | Encoding: 0 PCM, 1 ADPCM, 2 padding |
| rx_rst | output | 1 | Decompressor reset indication |
| rx_chan | output | CH_W | Channel of the received pair |
| tx_smp | input | 8 | Sample to transmit, taken at a first slot |
| tx_adpcm | input | 1 | Sample is ADPCM |
| tx_pad | input | 1 | Sample is padding |
| tx_talk | input | 1 | Force reset code (start of talk spurt) |
| tx_byte | output | 8 | Transmit slot byte |

## Verification
The hardest situation to reach is a truncated pair: a frame pulse arrives after the first slot of a pair that carries padding, and the same channel then sends voice in the next frame. A correct design gives no reset indication here, while a design that commits history too early gives one. The directed part of the bench builds exactly this sequence in both directions. The random part varies frame lengths from empty to longer than the pair range, so that truncated pairs and out-of-range slots occur many times, with random control bytes that include junk in the upper bits.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic [1:0] {
        CODE_PCM   = 2'b00,
        CODE_ADPCM = 2'b01,
        CODE_PAD   = 2'b10,
        CODE_RST   = 2'b11
    } ctl_code_e;

    typedef enum logic [1:0] {
        KIND_PCM   = 2'd0,
        KIND_ADPCM = 2'd1,
        KIND_PAD   = 2'd2
    } smp_kind_e;

    // transmit code selection: padding first, then reset, then encoding
    function automatic ctl_code_e pick_code(
        input logic pad,
        input logic adpcm,
        input logic was_pad,
        input logic talk
    );
        if (pad)
            return CODE_PAD;
        else if (was_pad || talk)
            return CODE_RST;
        else if (adpcm)
            return CODE_ADPCM;
        else
            return CODE_PCM;
    endfunction

    // receive code to sample kind
    function automatic smp_kind_e code_kind(input logic [1:0] code);
        case (code)
            CODE_PCM: return KIND_PCM;
            CODE_PAD: return KIND_PAD;
            default:  return KIND_ADPCM;
        endcase
    endfunction

endpackage

// File: rtl/tsp_slot_seq.sv
module tsp_slot_seq #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int LAST  = 2 * NUM_CH,
    localparam int CNT_W = $clog2(LAST + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_en,
    input  logic            frm_sync,
    output logic            pair_first,
    output logic            pair_second,
    output logic            slot_oor,
    output logic [CH_W-1:0] pair_idx
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s st_d, st_q;
    logic [CNT_W-1:0] idx;
    logic             in_rng;

    always_comb begin
        st_d   = st_q;
        idx    = frm_sync ? '0 : st_q.cnt;
        in_rng = (idx < CNT_W'(LAST));
        if (slot_en)
            st_d.cnt = in_rng ? idx + 1'b1 : CNT_W'(LAST);
        pair_first  = slot_en &  in_rng & ~idx[0];
        pair_second = slot_en &  in_rng &  idx[0];
        slot_oor    = slot_en & ~in_rng;
        pair_idx    = idx[CH_W:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.cnt <= CNT_W'(LAST);
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/tsp_rx_dec.sv
module tsp_rx_dec
    import tsp_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_first,
    input  logic            pair_second,
    input  logic [CH_W-1:0] pair_idx,
    input  logic [7:0]      rx_byte,
    output logic            rx_vld,
    output logic [7:0]      rx_smp,
    output logic [1:0]      rx_kind,
    output logic            rx_rst,
    output logic [CH_W-1:0] rx_chan
);

    typedef struct packed {
        logic [7:0]        hold;
        logic [NUM_CH-1:0] hist;
        logic              vld;
        logic [7:0]        smp;
        logic [1:0]        kind;
        logic              rst;
        logic [CH_W-1:0]   chan;
    } rx_s;

    rx_s       st_d, st_q;
    ctl_code_e code;
    logic      voice;

    always_comb begin
        st_d   = st_q;
        st_d.vld = 1'b0;
        code   = ctl_code_e'(rx_byte[1:0]);
        voice  = (code != CODE_PAD);
        if (pair_first)
            st_d.hold = rx_byte;
        if (pair_second) begin
            st_d.vld  = 1'b1;
            st_d.smp  = st_q.hold;
            st_d.kind = code_kind(code);
            st_d.rst  = voice & ((code == CODE_RST) | st_q.hist[pair_idx]);
            st_d.chan = pair_idx;
            st_d.hist[pair_idx] = ~voice;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rx_vld  = st_q.vld;
    assign rx_smp  = st_q.smp;
    assign rx_kind = st_q.kind;
    assign rx_rst  = st_q.rst;
    assign rx_chan = st_q.chan;

endmodule

// File: rtl/tsp_tx_enc.sv
module tsp_tx_enc
    import tsp_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_first,
    input  logic            pair_second,
    input  logic            slot_oor,
    input  logic [CH_W-1:0] pair_idx,
    input  logic [7:0]      tx_smp,
    input  logic            tx_adpcm,
    input  logic            tx_pad,
    input  logic            tx_talk,
    output logic [7:0]      tx_byte
);

    typedef struct packed {
        logic [7:0]        obyte;
        logic [1:0]        code;
        logic [NUM_CH-1:0] hist;
    } tx_s;

    tx_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pair_first) begin
            st_d.code  = pick_code(tx_pad, tx_adpcm, st_q.hist[pair_idx], tx_talk);
            st_d.obyte = tx_smp;
        end
        if (pair_second) begin
            st_d.obyte = {6'b000000, st_q.code};
            st_d.hist[pair_idx] = (st_q.code == CODE_PAD);
        end
        if (slot_oor)
            st_d.obyte = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tx_byte = st_q.obyte;

endmodule

// File: rtl/tsp_iface.sv
module tsp_iface #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_en,
    input  logic            frm_sync,
    input  logic [7:0]      rx_byte,
    output logic            rx_vld,
    output logic [7:0]      rx_smp,
    output logic [1:0]      rx_kind,
    output logic            rx_rst,
    output logic [CH_W-1:0] rx_chan,
    input  logic [7:0]      tx_smp,
    input  logic            tx_adpcm,
    input  logic            tx_pad,
    input  logic            tx_talk,
    output logic [7:0]      tx_byte
);

    logic            pair_first;
    logic            pair_second;
    logic            slot_oor;
    logic [CH_W-1:0] pair_idx;

    tsp_slot_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_en     (slot_en),
        .frm_sync    (frm_sync),
        .pair_first  (pair_first),
        .pair_second (pair_second),
        .slot_oor    (slot_oor),
        .pair_idx    (pair_idx)
    );

    tsp_rx_dec #(.NUM_CH(NUM_CH)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_first  (pair_first),
        .pair_second (pair_second),
        .pair_idx    (pair_idx),
        .rx_byte     (rx_byte),
        .rx_vld      (rx_vld),
        .rx_smp      (rx_smp),
        .rx_kind     (rx_kind),
        .rx_rst      (rx_rst),
        .rx_chan     (rx_chan)
    );

    tsp_tx_enc #(.NUM_CH(NUM_CH)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_first  (pair_first),
        .pair_second (pair_second),
        .slot_oor    (slot_oor),
        .pair_idx    (pair_idx),
        .tx_smp      (tx_smp),
        .tx_adpcm    (tx_adpcm),
        .tx_pad      (tx_pad),
        .tx_talk     (tx_talk),
        .tx_byte     (tx_byte)
    );

endmodule

// File: rtl/tsp_iface_chk.sv
module tsp_iface_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pair_first,
    input logic       pair_second,
    input logic       slot_oor,
    input logic [7:0] tx_smp,
    input logic [7:0] tx_byte,
    input logic       rx_vld,
    input logic [1:0] rx_kind,
    input logic       rx_rst
);

    // R2: receive output only after a completed pair
    a_r2_vld_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> $past(pair_second));

    // R3: the reported kind is one of the three legal values
    a_r3_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> (rx_kind != 2'b11));

    // R4: a padding sample never carries the reset flag
    a_r4_pad_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_kind == 2'd2) |-> !rx_rst);

    // R5: the sample byte follows the first slot
    a_r5_tx_sample: assert property (@(posedge clk) disable iff (!rst_n)
        pair_first |=> (tx_byte == $past(tx_smp)));

    // R5: the control byte keeps its upper bits clear
    a_r5_ctl_upper: assert property (@(posedge clk) disable iff (!rst_n)
        pair_second |=> (tx_byte[7:2] == 6'b0));

    // R9: an out-of-range slot sends zero
    a_r9_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        slot_oor |=> (tx_byte == 8'h00));

endmodule

bind tsp_iface tsp_iface_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pair_first  (pair_first),
    .pair_second (pair_second),
    .slot_oor    (slot_oor),
    .tx_smp      (tx_smp),
    .tx_byte     (tx_byte),
    .rx_vld      (rx_vld),
    .rx_kind     (rx_kind),
    .rx_rst      (rx_rst)
);

// File: tb/sim_tsp_iface.sv
module sim_tsp_iface;

    localparam int N    = 8;
    localparam int CH_W = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            slot_en = 1'b0;
    logic            frm_sync = 1'b0;
    logic [7:0]      rx_byte = '0;
    logic            rx_vld;
    logic [7:0]      rx_smp;
    logic [1:0]      rx_kind;
    logic            rx_rst;
    logic [CH_W-1:0] rx_chan;
    logic [7:0]      tx_smp = '0;
    logic            tx_adpcm = 1'b0;
    logic            tx_pad = 1'b0;
    logic            tx_talk = 1'b0;
    logic [7:0]      tx_byte;

    int checks = 0;
    int errors = 0;

    // bench reference state
    int         m_cnt = 2 * N;
    logic [7:0] m_hold = '0;
    bit         m_rxh [N];
    bit         m_txh [N];
    logic [1:0] m_code = '0;
    logic [7:0] e_tx = '0;

    always #10ns clk = ~clk;

    tsp_iface #(.NUM_CH(N)) u0 (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_kind(input logic [1:0] c);
        return (c == 2'b00) ? 2'd0 : (c == 2'b10) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] ref_code(input bit pd, input bit ad, input bit h, input bit tk);
        if (pd) return 2'b10;
        if (h || tk) return 2'b11;
        return ad ? 2'b01 : 2'b00;
    endfunction

    // one slot strobe plus idle gap cycles, with reference update and checks
    task automatic slot(input bit fs, input logic [7:0] rb, input logic [7:0] ts,
                        input bit ad, input bit pd, input bit tk, input int gap);
        int         idx;
        int         p;
        bit         first;
        bit         second;
        bit         e_vld;
        logic [7:0] e_smp;
        logic [1:0] e_kind;
        bit         e_rst;
        @(negedge clk);
        slot_en  = 1'b1;
        frm_sync = fs;
        rx_byte  = rb;
        tx_smp   = ts;
        tx_adpcm = ad;
        tx_pad   = pd;
        tx_talk  = tk;
        idx    = fs ? 0 : m_cnt;
        first  = (idx < 2 * N) && (idx % 2 == 0);
        second = (idx < 2 * N) && (idx % 2 == 1);
        p      = idx / 2;
        m_cnt  = (idx < 2 * N) ? idx + 1 : 2 * N;
        e_vld  = 1'b0;
        e_smp  = '0;
        e_kind = '0;
        e_rst  = 1'b0;
        if (first) begin
            m_hold = rb;
            m_code = ref_code(pd, ad, m_txh[p], tk);
            e_tx   = ts;
        end else if (second) begin
            e_vld  = 1'b1;
            e_smp  = m_hold;
            e_kind = ref_kind(rb[1:0]);
            e_rst  = (rb[1:0] != 2'b10) && ((rb[1:0] == 2'b11) || m_rxh[p]);
            m_rxh[p] = (rb[1:0] == 2'b10);
            e_tx   = {6'b0, m_code};
            m_txh[p] = (m_code == 2'b10);
        end else begin
            e_tx = 8'h00;
        end
        @(negedge clk);
        slot_en  = 1'b0;
        frm_sync = 1'b0;
        check(rx_vld == e_vld, "R2/R1/R7 rx_vld", int'(rx_vld), int'(e_vld));
        check(tx_byte == e_tx, "R5/R6/R9 tx_byte", int'(tx_byte), int'(e_tx));
        if (e_vld) begin
            check(rx_smp == e_smp, "R2 rx_smp", int'(rx_smp), int'(e_smp));
            check(rx_chan == CH_W'(p), "R2 rx_chan", int'(rx_chan), p);
            check(rx_kind == e_kind, "R3 rx_kind", int'(rx_kind), int'(e_kind));
            check(rx_rst == e_rst, "R3/R4 rx_rst", int'(rx_rst), int'(e_rst));
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(rx_vld == 1'b0, "R2 single-cycle rx_vld", int'(rx_vld), 0);
            check(tx_byte == e_tx, "R5 tx_byte hold", int'(tx_byte), int'(e_tx));
        end
    endtask

    initial begin
        #(20ns * 150000);
        $display("FAIL watchdog act=0 exp=1");
        errors++;
        checks++;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int c = 0; c < N; c++) begin
            m_rxh[c] = 1'b0;
            m_txh[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        check(rx_vld == 1'b0, "R8 rx_vld at reset", int'(rx_vld), 0);
        check(rx_rst == 1'b0, "R8 rx_rst at reset", int'(rx_rst), 0);
        check(tx_byte == 8'h00, "R8 tx_byte at reset", int'(tx_byte), 0);
        rst_n = 1'b1;

        // R1, R9: strobes before any frame pulse are out of range
        slot(0, 8'h55, 8'hAA, 0, 0, 0, 1);
        slot(0, 8'h01, 8'h33, 1, 0, 0, 0);

        // frame 1: pair 0 PCM, pair 1 padding, pair 2 ADPCM with junk upper bits
        slot(1, 8'h11, 8'h21, 0, 0, 0, 0);
        slot(0, 8'h00, 8'h00, 0, 0, 0, 1);
        slot(0, 8'h12, 8'h22, 0, 1, 0, 0);
        slot(0, 8'hFE, 8'h00, 0, 0, 0, 0);   // R3: code 10 with upper bits set
        slot(0, 8'h13, 8'h23, 1, 0, 0, 2);
        slot(0, 8'hFD, 8'h00, 0, 0, 0, 0);   // R3: code 01 with upper bits set
        // R7: truncated pair 3 carries padding in both directions
        slot(0, 8'h14, 8'h24, 0, 1, 0, 0);
        // frame 2: pair 1 voice after padding -> reset (R4, R6)
        slot(1, 8'h15, 8'h25, 0, 0, 0, 0);
        slot(0, 8'h00, 8'h00, 0, 0, 0, 0);
        slot(0, 8'h16, 8'h26, 1, 0, 0, 0);
        slot(0, 8'h01, 8'h00, 0, 0, 0, 0);
        slot(0, 8'h17, 8'h27, 0, 0, 1, 0);   // R6: talk start forces code 11
        slot(0, 8'hFF, 8'h00, 0, 0, 0, 0);   // R3: code 11 with upper bits set
        // R7: pair 3 voice after truncated padding -> no reset expected
        slot(0, 8'h18, 8'h28, 1, 0, 0, 0);
        slot(0, 8'h01, 8'h00, 0, 0, 0, 0);

        // random frames of varied length
        for (int f = 0; f < 60; f++) begin
            int len;
            len = $urandom_range(0, 2 * N + 3);
            for (int s = 0; s < len; s++) begin
                slot(s == 0, 8'($urandom), 8'($urandom), 1'($urandom),
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                     $urandom_range(0, 2));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule